// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the internal access address of a pipelined burst memory. A load command captures an external base address; each following advance command moves the two lowest address bits to the next beat of a four-beat burst, while the upper bits stay where the load put them. The beat order is chosen by a strap input: linear order adds the beat count to the starting offset modulo four, and interleaved order XORs the starting offset with the beat count.

Commands are qualified by an active-low clock enable. While the enable is inactive, the address, the beat count and the valid flag all hold. A load command that arrives with the select indication low deselects the block: it clears the burst-valid flag. Later advance commands are then ignored until a fresh load arrives. The order strap is meant to be tied off. The tie-off value of 1, which selects interleaved order, is the value used when no linear order is wanted.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it rises, `cur_addr` is 0 and `burst_vld` is 0.
- R2: A rising edge with `clk_en_n`=0, `adv_ld`=0 and `sel`=1 is a load. One cycle later, `cur_addr` equals the sampled `ext_addr`, `burst_vld` is 1 and the beat count is 0.
- R3: With `order_il`=0 (linear), the n-th advance after a load sets `cur_addr[1:0]` to (start + n) mod 4, where start is the loaded value of bits [1:0]. The count wraps after four beats.
- R4: With `order_il`=1 (interleaved), the n-th advance sets `cur_addr[1:0]` to start XOR (n mod 4).
- R5: An advance never changes `cur_addr` above bit 1.
- R6: A rising edge with `clk_en_n`=1 changes neither `cur_addr` nor `burst_vld`, and it does not move the beat count, whatever `adv_ld`, `sel` and `ext_addr` carry.
- R7: A rising edge with `clk_en_n`=0, `adv_ld`=0 and `sel`=0 clears `burst_vld` one cycle later. Advances that arrive while `burst_vld` is 0 leave `cur_addr` and `burst_vld` unchanged until the next load.
- R8: `sel` is sampled only on load commands. An advance with `sel`=0 still steps the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high holds all state |
| adv_ld | input | 1 | 1 = advance burst, 0 = load or deselect |
| sel | input | 1 | Select indication sampled on load commands |
| order_il | input | 1 | Order strap: 1 interleaved, 0 linear |
| ext_addr | input | 18 | External base address |
| cur_addr | output | 18 | Current internal access address (registered) |
| burst_vld | output | 1 | Burst valid: a loaded address is active |

## Verification
Both outputs are registered, so every command sampled at rising edge k shows up on `cur_addr` and `burst_vld` one cycle later. The results are read at the falling edge that follows edge k. The bench drives its inputs at falling edges and updates a behavioural model at each rising edge from the same sampled inputs. At every falling edge it compares both outputs with the model before it applies the next stimulus, so each comparison lines up with the one-cycle latency. All four start offsets are exercised in both orders. The runs include clock-enable stalls in the middle of a burst, wraps past four beats, advances while deselected and advances with `sel` low.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_DESEL = 2'd2,
    CMD_ADV   = 2'd3
  } burst_cmd_e;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_en_n,
  input  logic       adv_ld,
  input  logic       sel,
  output burst_cmd_e cmd,
  output logic       vld_q
);
  logic vld_d;

  always_comb begin
    if (clk_en_n)     cmd = CMD_HOLD;
    else if (!adv_ld) cmd = sel ? CMD_LOAD : CMD_DESEL;
    else if (vld_q)   cmd = CMD_ADV;
    else              cmd = CMD_HOLD;
  end

  always_comb begin
    vld_d = vld_q;
    case (cmd)
      CMD_LOAD:  vld_d = 1'b1;
      CMD_DESEL: vld_d = 1'b0;
      default:   vld_d = vld_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  // R7: deselect drops valid, and a stray advance cannot raise it
  assert_desel_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv_ld && !sel) |=> !vld_q);
  assert_no_adv_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv_ld && !vld_q) |=> !vld_q);
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  burst_cmd_e        cmd,
  input  logic [BEAT_W-1:0] load_start,
  output logic [BEAT_W-1:0] start_q,
  output logic [BEAT_W-1:0] beat_nxt
);
  logic [BEAT_W-1:0] beat_q, beat_d, start_d;

  assign beat_nxt = beat_q + 1'b1;

  always_comb begin
    beat_d  = beat_q;
    start_d = start_q;
    case (cmd)
      CMD_LOAD: begin
        beat_d  = '0;
        start_d = load_start;
      end
      CMD_ADV: beat_d = beat_nxt;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q  <= '0;
      start_q <= '0;
    end else begin
      beat_q  <= beat_d;
      start_q <= start_d;
    end
  end

  // R6: beat count holds when no advance or load is issued
  assert_beat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_HOLD || cmd == CMD_DESEL) |=> $stable(beat_q) && $stable(start_q));
  // R2: a load restarts the beat count
  assert_beat_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LOAD) |=> beat_q == '0);
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  burst_order_e      order,
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] offset
);
  logic [BEAT_W-1:0] lin_off, il_off;

  assign lin_off = start + beat;

  genvar gi;
  generate
    for (gi = 0; gi < BEAT_W; gi++) begin : g_il_bit
      assign il_off[gi] = start[gi] ^ beat[gi];
    end
  endgenerate

  always_comb begin
    case (order)
      ORD_INTERLEAVE: offset = il_off;
      default:        offset = lin_off;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              adv_ld,
  input  logic              sel,
  input  logic              order_il,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              burst_vld
);
  localparam int UP_W = ADDR_W - BEAT_W;

  burst_cmd_e        cmd;
  burst_order_e      order;
  logic [BEAT_W-1:0] start_q, beat_nxt, step_off;
  logic [ADDR_W-1:0] addr_q, addr_d;

  assign order = burst_order_e'(order_il);

  burst_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_n (clk_en_n),
    .adv_ld   (adv_ld),
    .sel      (sel),
    .cmd      (cmd),
    .vld_q    (burst_vld)
  );

  burst_beat_cnt #(.BEAT_W(BEAT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .load_start (ext_addr[BEAT_W-1:0]),
    .start_q    (start_q),
    .beat_nxt   (beat_nxt)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .order  (order),
    .start  (start_q),
    .beat   (beat_nxt),
    .offset (step_off)
  );

  always_comb begin
    addr_d = addr_q;
    case (cmd)
      CMD_LOAD: addr_d = ext_addr;
      CMD_ADV:  addr_d = {addr_q[ADDR_W-1:BEAT_W], step_off};
      default:  addr_d = addr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign cur_addr = addr_q;

  // R2: load captures the external address and validates the burst
  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv_ld && sel) |=> (cur_addr == $past(ext_addr)) && burst_vld);
  // R6: disabled clock freezes outputs
  assert_enable_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> $stable(cur_addr) && $stable(burst_vld));
  // R5: advance keeps the upper address bits
  assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv_ld && burst_vld) |=>
      cur_addr[ADDR_W-1:BEAT_W] == $past(cur_addr[ADDR_W-1:BEAT_W]));
  // R3: linear order steps the low bits by one, modulo the burst length
  assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv_ld && burst_vld && !order_il) |=>
      cur_addr[BEAT_W-1:0] == $past(cur_addr[BEAT_W-1:0]) + 1'b1);
  // R7: an advance without a valid burst leaves the address alone
  assert_idle_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv_ld && !burst_vld) |=> $stable(cur_addr));

  initial begin
    assert_width_ok: assert (UP_W >= 0);
  end
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clk_en_n, adv_ld, sel, order_il;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] cur_addr;
  logic          burst_vld;

  always #2.5 clk = ~clk;

  burst_addr_seq u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_ld(adv_ld),
    .sel(sel), .order_il(order_il), .ext_addr(ext_addr),
    .cur_addr(cur_addr), .burst_vld(burst_vld)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // behavioural reference
  logic [AW-1:0] m_addr;
  logic          m_vld;
  int            m_start, m_n;
  string         m_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr = '0; m_vld = 0; m_start = 0; m_n = 0; m_tag = "R1";
    end else if (clk_en_n) begin
      m_tag = "R6";
    end else if (!adv_ld) begin
      if (sel) begin
        m_addr = ext_addr; m_vld = 1; m_start = int'(ext_addr[1:0]); m_n = 0; m_tag = "R2";
      end else begin
        m_vld = 0; m_tag = "R7";
      end
    end else if (m_vld) begin
      m_n = (m_n + 1) % 4;
      if (order_il) m_addr[1:0] = 2'(m_start ^ m_n);
      else          m_addr[1:0] = 2'((m_start + m_n) % 4);
      m_tag = !sel ? "R8" : (order_il ? "R4" : "R3");
    end else begin
      m_tag = "R7";
    end
  end

  task automatic compare();
    n_cmp++;
    if (cur_addr[1:0] !== m_addr[1:0] || burst_vld !== m_vld) begin
      n_bad++;
      $display("FAIL %s: addr_lo=%0d vld=%0b expected addr_lo=%0d vld=%0b",
               m_tag, cur_addr[1:0], burst_vld, m_addr[1:0], m_vld);
    end
    n_cmp++;
    if (cur_addr[AW-1:2] !== m_addr[AW-1:2]) begin
      n_bad++;
      $display("FAIL R5 (%s): addr_hi=%h expected %h", m_tag, cur_addr[AW-1:2], m_addr[AW-1:2]);
    end
  endtask

  task automatic step(input logic en_n, input logic al, input logic s, input logic [AW-1:0] a);
    clk_en_n = en_n; adv_ld = al; sel = s; ext_addr = a;
    @(negedge clk);
    compare();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; clk_en_n = 1; adv_ld = 1; sel = 0; order_il = 1; ext_addr = '0;
    @(negedge clk); compare();       // R1 during reset
    @(negedge clk); compare();
    rst_n = 1;
    @(negedge clk); compare();       // R1 after release
    for (int mo = 0; mo < 2; mo++) begin
      order_il = mo[0];
      for (int st = 0; st < 4; st++) begin
        logic [AW-1:0] base;
        base = {16'(16'h1a5 * (st + 3) + mo * 16'h0c3), st[1:0]};
        step(0, 0, 1, base);         // R2 load
        step(0, 1, 1, '1);           // R3/R4 beat 1
        step(1, 1, 1, '0);           // R6 stall
        step(1, 0, 1, 18'h3ffff);    // R6 ignored load
        step(0, 1, 0, '0);           // R8 beat 2 with sel low
        step(0, 1, 1, '0);           // beat 3
        step(0, 1, 1, '0);           // wrap to beat 0
        step(0, 1, 1, '0);           // beat 1 again
      end
    end
    order_il = 0;
    step(0, 0, 1, 18'h2aaa6);
    step(0, 0, 0, 18'h11111);        // R7 deselect
    step(0, 1, 1, '0);               // R7 advance ignored
    step(0, 1, 0, '0);
    step(1, 0, 1, 18'h0f0f3);        // R6 stalled load ignored
    step(0, 1, 1, '0);               // still idle
    step(0, 0, 1, 18'h0f0f3);        // R2 reload
    step(0, 1, 1, '0);
    step(0, 1, 1, '0);
    finish_run();
  end
endmodule